// File: doc/BRIEF.md
# Two-Window I2C Target with Clock Stretching

This block is an I2C target (slave) that gives an external bus controller access to two byte buffers. One is a 16-byte read/write RAM window. The other is a 16-byte constant ROM window whose contents are fixed by a parameter at elaboration. The two windows sit at two bus addresses that differ only in address bit 6. Both bus lines are sampled through synchronizers. The block only ever pulls a line low or lets it go.

A transfer goes through a fixed sequence. After a START, the block receives the address byte and decides whether to answer. It then holds SCL low for a fixed number of cycles after the eighth bit of every byte it takes part in. This gives the internal logic time to store or fetch a byte before the acknowledge slot.

In a write, the first data byte becomes the buffer offset, and each later byte is stored at the next offset. In a read, bytes are served from the current offset. The offset advances after every byte that the controller acknowledges.

The controller in the FSM has eight named states:
- **IDLE**: the bus is free. Entered on reset or STOP.
- **ADDR**: shifts in the address byte. Entered on every START, including a repeated START.
- **STRETCH**: holds SCL low and presents this block's ACK or NACK on SDA.
- **ACK_OUT**: keeps driving the ACK until SCL falls.
- **WR_BYTE**: shifts in an offset byte or a data byte.
- **RD_BYTE**: shifts out a data byte, MSB first.
- **RD_ACK**: samples the controller's ACK.
- **WAIT**: ignores the bus until the next START or STOP.

The transitions are:
- ADDR→STRETCH on a matching address.
- ADDR→WAIT on a non-matching address, with no stretch.
- STRETCH→ACK_OUT when it has acknowledged.
- STRETCH→WAIT when it has refused.
- STRETCH→RD_ACK after a byte it transmitted.
- ACK_OUT→WR_BYTE or ACK_OUT→RD_BYTE on the ninth SCL fall, according to the R/W bit.
- WR_BYTE→STRETCH on the eighth fall.
- RD_BYTE→STRETCH on the eighth fall.
- RD_ACK→RD_BYTE when the controller acknowledged.
- RD_ACK→WAIT when the controller did not.
- Any state→ADDR on START.
- Any state→IDLE on STOP.

Top module: `i2c_dual_window_slave`

## Requirements
- R1: While reset is asserted, and afterwards until a START is seen, `scl_pull` and `sda_pull` are both 0, so both lines stay released.
- R2: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START at any point, including part way through a data byte, discards the partial byte and restarts address reception.
- R3: With `rom_window_en`=0, the received 7-bit address must equal all 7 bits of `own_addr`, which may be 0 to 127. The RAM window is then used.
- R4: With `rom_window_en`=1, only received address bits 5:0 are compared with `own_addr[5:0]`. Received bit 6 = 0 selects RAM and bit 6 = 1 selects ROM; for example, own address 0x0A gives RAM at 0x0A and ROM at 0x4A. On a mismatch, SDA stays released, there is no stretch, and the bus is ignored until the next START.
- R5: The address byte is address<<1 | R/W, where R/W=1 is a read. Bytes travel MSB first, and an ACK is SDA low in the ninth clock. In a write, the first data byte sets the offset and is acknowledged. Each later byte is stored at the offset, which then increments.
- R6: A RAM data byte written at an offset of 16 or more is answered with a NACK and is not stored.
- R7: A data byte written to the ROM window is answered with a NACK, and the ROM content is unchanged. The offset byte of a ROM write is still acknowledged.
- R8: A read returns the byte at the current offset. The offset increments after each byte that the controller acknowledges. After a controller NACK, SDA is released until the next START or STOP.
- R9: Reading at an offset past the end of the selected window returns 0xFF.
- R10: After the eighth SCL falling edge of every byte the block takes part in, SCL is held low for STRETCH_CYCLES clock cycles. SCL is never held at any other time.
- R11: `sda_pull` changes only while SCL is low.
- R12: ROM byte i is `ROM_IMAGE[8*i+7 : 8*i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the SCL bus line |
| sda_i | input | 1 | Sensed level of the SDA bus line |
| scl_pull | output | 1 | 1 pulls SCL low; 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low; 0 releases it |
| own_addr | input | 7 | Configured target address |
| rom_window_en | input | 1 | 1 enables the ROM window at address bit 6 set |

## Verification
The assertions assume that the controller changes SDA only while SCL is low, except when it makes a START or a STOP. They also assume that it never issues a START or STOP while this block is pulling SDA low, and that SCL high and low phases last much longer than the synchronizer delay. The bench controller keeps to these rules. It drives each level for ten clock cycles per half period. It changes SDA only after it has itself pulled SCL low. It makes repeated STARTs only at points where the block has released SDA. `own_addr` and `rom_window_en` are changed only while the bus is idle.

// File: rtl/i2c_dw_pkg.sv
package i2c_dw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_STRETCH,
        ST_ACK_OUT,
        ST_WR_BYTE,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_WAIT
    } tgt_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_OFFSET,
        PH_WDATA,
        PH_RDATA
    } byte_phase_t;

    localparam int BYTE_BITS = 8;

endpackage

// File: rtl/i2c_dw_sync.sv
module i2c_dw_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    // Reset to all ones: a released bus reads high, so no false edge appears.
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_dw_cond.sv
module i2c_dw_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = !scl_q && scl_s;
    assign scl_fall  = scl_q && !scl_s;
    assign start_det = scl_q && scl_s && sda_q && !sda_s;
    assign stop_det  = scl_q && scl_s && !sda_q && sda_s;

endmodule

// File: rtl/i2c_dw_store.sv
module i2c_dw_store #(
    parameter int                    RAM_BYTES = 16,
    parameter int                    ROM_BYTES = 16,
    parameter logic [ROM_BYTES*8-1:0] ROM_IMAGE = '0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic       rd_rom,
    input  logic [7:0] rd_idx,
    output logic [7:0] rd_data
);

    localparam int RAM_IW = (RAM_BYTES > 1) ? $clog2(RAM_BYTES) : 1;
    localparam int ROM_IW = (ROM_BYTES > 1) ? $clog2(ROM_BYTES) : 1;

    logic [7:0] ram_q   [RAM_BYTES];
    logic [7:0] rom_mem [ROM_BYTES];

    // Constant window: one byte lane per generate iteration.
    for (genvar g = 0; g < ROM_BYTES; g++) begin : g_rom
        assign rom_mem[g] = ROM_IMAGE[g*8 +: 8];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < RAM_BYTES; i++) begin
                ram_q[i] <= '0;
            end
        end else if (wr_en && (int'(wr_idx) < RAM_BYTES)) begin
            ram_q[wr_idx[RAM_IW-1:0]] <= wr_data;
        end
    end

    always_comb begin
        rd_data = 8'hFF;
        if (rd_rom) begin
            if (int'(rd_idx) < ROM_BYTES) rd_data = rom_mem[rd_idx[ROM_IW-1:0]];
        end else begin
            if (int'(rd_idx) < RAM_BYTES) rd_data = ram_q[rd_idx[RAM_IW-1:0]];
        end
    end

endmodule

// File: rtl/i2c_dual_window_slave.sv
module i2c_dual_window_slave
    import i2c_dw_pkg::*;
#(
    parameter int                    RAM_BYTES      = 16,
    parameter int                    ROM_BYTES      = 16,
    parameter int                    STRETCH_CYCLES = 24,
    parameter int                    SYNC_STAGES    = 2,
    parameter logic [ROM_BYTES*8-1:0] ROM_IMAGE     = {ROM_BYTES{8'hA5}}
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       scl_pull,
    output logic       sda_pull,
    input  logic [6:0] own_addr,
    input  logic       rom_window_en
);

    localparam int STR_W = $clog2(STRETCH_CYCLES + 1);
    localparam logic [STR_W-1:0] STR_LAST = STR_W'(STRETCH_CYCLES - 1);

    // ---------------- line conditioning ----------------
    logic [1:0] line_raw;
    logic [1:0] line_sync;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;

    assign line_raw = {scl_i, sda_i};

    i2c_dw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (line_raw),
        .dout (line_sync)
    );

    assign scl_s = line_sync[1];
    assign sda_s = line_sync[0];

    i2c_dw_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    // ---------------- state and datapath registers ----------------
    tgt_state_t       state, state_nx;
    byte_phase_t      phase;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [7:0]       offset;
    logic             win_rom;
    logic             is_read;
    logic             drive_ack;
    logic             ctrl_turn;
    logic             ctrl_acked;
    logic [STR_W-1:0] str_cnt;

    // ---------------- buffer store ----------------
    logic       mem_we;
    logic [7:0] rd_byte;

    i2c_dw_store #(
        .RAM_BYTES(RAM_BYTES),
        .ROM_BYTES(ROM_BYTES),
        .ROM_IMAGE(ROM_IMAGE)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (mem_we),
        .wr_idx (offset),
        .wr_data(shreg),
        .rd_rom (win_rom),
        .rd_idx (offset),
        .rd_data(rd_byte)
    );

    // ---------------- decode ----------------
    logic [6:0] rx_addr;
    logic       rx_rw;
    logic       addr_hit;
    logic       addr_rom;
    logic       byte_done;
    logic       wr_ok;

    assign rx_addr   = shreg[7:1];
    assign rx_rw     = shreg[0];
    assign byte_done = scl_fall && (bit_cnt == 4'(BYTE_BITS));
    assign wr_ok     = !win_rom && (int'(offset) < RAM_BYTES);

    always_comb begin
        if (rom_window_en) begin
            addr_hit = (rx_addr[5:0] == own_addr[5:0]);
            addr_rom = rx_addr[6];
        end else begin
            addr_hit = (rx_addr == own_addr);
            addr_rom = 1'b0;
        end
    end

    assign mem_we = (state == ST_WR_BYTE) && byte_done && (phase == PH_WDATA) && wr_ok;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        if (stop_det) begin
            state_nx = ST_IDLE;
        end else if (start_det) begin
            state_nx = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:    state_nx = ST_IDLE;
                ST_ADDR:    if (byte_done) state_nx = addr_hit ? ST_STRETCH : ST_WAIT;
                ST_STRETCH: if (str_cnt == STR_LAST) begin
                                if (ctrl_turn)      state_nx = ST_RD_ACK;
                                else if (drive_ack) state_nx = ST_ACK_OUT;
                                else                state_nx = ST_WAIT;
                            end
                ST_ACK_OUT: if (scl_fall) state_nx = is_read ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE: if (byte_done) state_nx = ST_STRETCH;
                ST_RD_BYTE: if (scl_fall && (bit_cnt == 4'(BYTE_BITS - 1))) state_nx = ST_STRETCH;
                ST_RD_ACK:  if (scl_fall) state_nx = ctrl_acked ? ST_RD_BYTE : ST_WAIT;
                ST_WAIT:    state_nx = ST_WAIT;
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    // ---------------- datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase      <= PH_ADDR;
            bit_cnt    <= '0;
            shreg      <= '0;
            offset     <= '0;
            win_rom    <= 1'b0;
            is_read    <= 1'b0;
            drive_ack  <= 1'b0;
            ctrl_turn  <= 1'b0;
            ctrl_acked <= 1'b0;
            str_cnt    <= '0;
        end else if (start_det || stop_det) begin
            bit_cnt   <= '0;
            shreg     <= '0;
            drive_ack <= 1'b0;
            ctrl_turn <= 1'b0;
            phase     <= PH_ADDR;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        is_read   <= rx_rw;
                        win_rom   <= addr_rom;
                        drive_ack <= addr_hit;
                        ctrl_turn <= 1'b0;
                        phase     <= rx_rw ? PH_RDATA : PH_OFFSET;
                        str_cnt   <= '0;
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end
                    if (byte_done) begin
                        str_cnt   <= '0;
                        ctrl_turn <= 1'b0;
                        if (phase == PH_OFFSET) begin
                            offset    <= shreg;
                            drive_ack <= 1'b1;
                            phase     <= PH_WDATA;
                        end else begin
                            drive_ack <= wr_ok;
                            if (wr_ok) offset <= offset + 8'd1;
                        end
                    end
                end
                ST_STRETCH: begin
                    str_cnt <= str_cnt + STR_W'(1);
                end
                ST_ACK_OUT: begin
                    if (scl_fall) begin
                        bit_cnt <= '0;
                        if (is_read) shreg <= rd_byte;
                    end
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        shreg   <= {shreg[6:0], 1'b0};
                        bit_cnt <= bit_cnt + 4'd1;
                        if (bit_cnt == 4'(BYTE_BITS - 1)) begin
                            drive_ack <= 1'b0;
                            ctrl_turn <= 1'b1;
                            str_cnt   <= '0;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) begin
                        ctrl_acked <= !sda_s;
                        if (!sda_s) offset <= offset + 8'd1;
                    end
                    if (scl_fall && ctrl_acked) begin
                        shreg   <= rd_byte;
                        bit_cnt <= '0;
                    end
                end
                ST_IDLE, ST_WAIT: begin
                    bit_cnt <= '0;
                end
                default: begin
                    bit_cnt <= '0;
                end
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        scl_pull = (state == ST_STRETCH);
        sda_pull = 1'b0;
        unique case (state)
            ST_STRETCH, ST_ACK_OUT: sda_pull = drive_ack;
            ST_RD_BYTE:             sda_pull = !shreg[7];
            default:                sda_pull = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_dw_checker.sv
module i2c_dw_checker #(
    parameter int STRETCH_CYCLES = 24,
    parameter int RAM_BYTES      = 16
) (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       scl_pull,
    input logic       sda_pull,
    input logic       mem_we,
    input logic [7:0] mem_idx
);

    int unsigned hold_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hold_run <= 0;
        else if (scl_pull) hold_run <= hold_run + 1;
        else               hold_run <= 0;
    end

    // R1: both lines released while reset is applied
    p_released_in_reset_r1: assert property (@(posedge clk)
        !rst_n |-> (!scl_pull && !sda_pull));

    // R11: the data line is never touched during an SCL high phase
    p_sda_still_scl_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_pull));

    // R10: stretching begins only once the line is already low
    p_stretch_from_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> !scl_i);

    // R10: a stretch lasts no longer than the configured window
    p_stretch_bounded_r10: assert property (@(posedge clk) disable iff (!rst_n)
        scl_pull |-> (hold_run < STRETCH_CYCLES));

    // R6: the store is written only at offsets inside the RAM window
    p_write_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(mem_idx) < RAM_BYTES));

endmodule

bind i2c_dual_window_slave i2c_dw_checker #(
    .STRETCH_CYCLES(STRETCH_CYCLES),
    .RAM_BYTES     (RAM_BYTES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_i   (scl_i),
    .scl_pull(scl_pull),
    .sda_pull(sda_pull),
    .mem_we  (mem_we),
    .mem_idx (offset)
);

// File: tb/sim_i2c_dual_window_slave.sv
module sim_i2c_dual_window_slave;

    localparam int HALF    = 10;
    localparam int STRETCH = 24;
    localparam logic [127:0] ROM_IMG = 128'hF0E1D2C3B4A5968778695A4B3C2D1E0F;

    logic       clk = 1'b0;
    logic       rst_n = 1'b1;
    logic       m_scl = 1'b0;   // 1 = controller pulls SCL low
    logic       m_sda = 1'b0;   // 1 = controller pulls SDA low
    logic [6:0] own_addr = 7'h0A;
    logic       rom_en = 1'b1;
    logic       scl_pull, sda_pull;
    logic       scl_bus, sda_bus;

    int checks = 0;
    int fails  = 0;
    int od_bad = 0;
    int rst_bad = 0;
    logic prev_scl = 1'b1;
    logic prev_pull = 1'b0;
    logic [7:0] ram_m [16];
    logic [7:0] exp_q [$];

    always #10 clk = ~clk;

    assign scl_bus = !(m_scl || scl_pull);
    assign sda_bus = !(m_sda || sda_pull);

    i2c_dual_window_slave #(
        .RAM_BYTES(16), .ROM_BYTES(16), .STRETCH_CYCLES(STRETCH),
        .SYNC_STAGES(2), .ROM_IMAGE(ROM_IMG)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
        .scl_pull(scl_pull), .sda_pull(sda_pull),
        .own_addr(own_addr), .rom_window_en(rom_en)
    );

    // Per-clock reference rules: reset release (R1) and open-drain timing (R11)
    always @(negedge clk) begin
        if (!rst_n) begin
            if (scl_pull || sda_pull) rst_bad++;
        end else if (scl_bus && prev_scl && (sda_pull !== prev_pull)) begin
            od_bad++;
        end
        prev_scl  <= scl_bus;
        prev_pull <= sda_pull;
    end

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic hold(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic pull_sda, input logic exp_str,
                           input string req, output logic seen);
        int w;
        m_sda = pull_sda;
        hold(HALF);
        m_scl = 1'b0;
        #1;
        w = 0;
        while (!scl_bus && w < 2000) begin
            @(negedge clk);
            w++;
        end
        if (exp_str) chk(w > 0, "R10", {req, " stretch after eighth bit"}, w, 1);
        else         chk(w == 0, "R10", {req, " no stretch"}, w, 0);
        hold(HALF);
        seen = sda_bus;
        m_scl = 1'b1;
        hold(HALF);
    endtask

    task automatic start_c();
        m_sda = 1'b0;
        hold(HALF);
        m_scl = 1'b0;
        #1;
        while (!scl_bus) @(negedge clk);
        hold(HALF);
        m_sda = 1'b1;
        hold(HALF);
        m_scl = 1'b1;
        hold(HALF);
    endtask

    task automatic stop_c();
        m_sda = 1'b1;
        hold(HALF);
        m_scl = 1'b0;
        #1;
        while (!scl_bus) @(negedge clk);
        hold(HALF);
        m_sda = 1'b0;
        hold(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic exp_str,
                             input string req, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(!b[i], 1'b0, req, s);
        clk_bit(1'b0, exp_str, req, s);
        acked = !s;
    endtask

    task automatic recv_byte(input logic give_ack, input string req,
                             output logic [7:0] b);
        logic s;
        b = '0;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b0, 1'b0, req, s);
            b = {b[6:0], s};
        end
        clk_bit(give_ack, 1'b1, req, s);
    endtask

    task automatic recv_check(input logic give_ack, input string req);
        logic [7:0] got;
        logic [7:0] want;
        recv_byte(give_ack, req, got);
        want = exp_q.pop_front();
        chk(got == want, req, "read byte", got, want);
    endtask

    task automatic ack_is(input logic got, input logic want, input string req,
                          input string what);
        chk(got == want, req, what, got, want);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic a;
        for (int i = 0; i < 16; i++) ram_m[i] = 8'h00;
        #1 rst_n = 1'b0;
        hold(6);
        chk(!scl_pull && !sda_pull, "R1", "lines during reset", {scl_pull, sda_pull}, 0);
        rst_n = 1'b1;
        hold(20);
        chk(!scl_pull && !sda_pull, "R1", "lines after reset", {scl_pull, sda_pull}, 0);

        // R5: RAM write, offset 2, three bytes
        start_c();
        send_byte(8'h14, 1'b1, "R4", a); ack_is(a, 1'b1, "R4", "RAM address ack");
        send_byte(8'h02, 1'b1, "R5", a); ack_is(a, 1'b1, "R5", "offset ack");
        send_byte(8'h11, 1'b1, "R5", a); ack_is(a, 1'b1, "R5", "data ack");
        send_byte(8'h22, 1'b1, "R5", a); ack_is(a, 1'b1, "R5", "data ack");
        send_byte(8'h33, 1'b1, "R5", a); ack_is(a, 1'b1, "R5", "data ack");
        stop_c();
        ram_m[2] = 8'h11; ram_m[3] = 8'h22; ram_m[4] = 8'h33;

        // R8: read back from offset 2, ack, ack, nack -> offset ends at 4
        start_c();
        send_byte(8'h14, 1'b1, "R8", a);
        send_byte(8'h02, 1'b1, "R8", a);
        start_c();
        send_byte(8'h15, 1'b1, "R8", a); ack_is(a, 1'b1, "R8", "read address ack");
        exp_q.push_back(ram_m[2]); exp_q.push_back(ram_m[3]); exp_q.push_back(ram_m[4]);
        recv_check(1'b1, "R8");
        recv_check(1'b1, "R8");
        recv_check(1'b0, "R8");
        chk(!sda_pull, "R8", "SDA released after controller NACK", sda_pull, 0);
        stop_c();

        // R8: new read without offset starts where the last acked byte left it
        start_c();
        send_byte(8'h15, 1'b1, "R8", a);
        exp_q.push_back(ram_m[4]);
        recv_check(1'b0, "R8");
        stop_c();

        // R12/R4: ROM window at 0x4A
        start_c();
        send_byte(8'h94, 1'b1, "R4", a); ack_is(a, 1'b1, "R4", "ROM address ack");
        send_byte(8'h00, 1'b1, "R4", a);
        start_c();
        send_byte(8'h95, 1'b1, "R12", a);
        for (int i = 0; i < 4; i++) exp_q.push_back(ROM_IMG[i*8 +: 8]);
        recv_check(1'b1, "R12");
        recv_check(1'b1, "R12");
        recv_check(1'b1, "R12");
        recv_check(1'b0, "R12");
        stop_c();

        // R7: ROM data write refused, content unchanged
        start_c();
        send_byte(8'h94, 1'b1, "R7", a);
        send_byte(8'h01, 1'b1, "R7", a); ack_is(a, 1'b1, "R7", "ROM offset ack");
        send_byte(8'h5A, 1'b1, "R7", a); ack_is(a, 1'b0, "R7", "ROM data nack");
        stop_c();
        start_c();
        send_byte(8'h94, 1'b1, "R7", a);
        send_byte(8'h01, 1'b1, "R7", a);
        start_c();
        send_byte(8'h95, 1'b1, "R7", a);
        exp_q.push_back(ROM_IMG[15:8]);
        recv_check(1'b0, "R7");
        stop_c();

        // R6/R9: end of RAM window
        start_c();
        send_byte(8'h14, 1'b1, "R6", a);
        send_byte(8'h0F, 1'b1, "R6", a);
        send_byte(8'h77, 1'b1, "R6", a); ack_is(a, 1'b1, "R6", "last slot ack");
        send_byte(8'h88, 1'b1, "R6", a); ack_is(a, 1'b0, "R6", "past end nack");
        stop_c();
        ram_m[15] = 8'h77;
        start_c();
        send_byte(8'h14, 1'b1, "R9", a);
        send_byte(8'h0F, 1'b1, "R9", a);
        start_c();
        send_byte(8'h15, 1'b1, "R9", a);
        exp_q.push_back(ram_m[15]); exp_q.push_back(8'hFF);
        recv_check(1'b1, "R6");
        recv_check(1'b0, "R9");
        stop_c();

        // R4: foreign address ignored, no ack, no stretch
        start_c();
        send_byte(8'h16, 1'b0, "R4", a); ack_is(a, 1'b0, "R4", "foreign address nack");
        send_byte(8'h00, 1'b0, "R4", a); ack_is(a, 1'b0, "R4", "ignored byte nack");
        stop_c();

        // R2: repeated START in the middle of a data byte restarts addressing
        start_c();
        send_byte(8'h14, 1'b1, "R2", a);
        send_byte(8'h05, 1'b1, "R2", a);
        begin
            logic s;
            clk_bit(1'b0, 1'b0, "R2", s);
            clk_bit(1'b0, 1'b0, "R2", s);
            clk_bit(1'b0, 1'b0, "R2", s);
        end
        start_c();
        send_byte(8'h15, 1'b1, "R2", a); ack_is(a, 1'b1, "R2", "address after restart");
        exp_q.push_back(ram_m[5]);
        recv_check(1'b0, "R2");
        stop_c();

        // R3: ROM window off, full 7-bit compare
        rom_en = 1'b0;
        hold(5);
        start_c();
        send_byte(8'h94, 1'b0, "R3", a); ack_is(a, 1'b0, "R3", "bit6 address refused");
        stop_c();
        own_addr = 7'h55;
        hold(5);
        start_c();
        send_byte(8'hAA, 1'b1, "R3", a); ack_is(a, 1'b1, "R3", "high address ack");
        send_byte(8'h00, 1'b1, "R3", a);
        send_byte(8'h99, 1'b1, "R3", a); ack_is(a, 1'b1, "R3", "RAM data ack");
        stop_c();
        ram_m[0] = 8'h99;
        start_c();
        send_byte(8'hAA, 1'b1, "R3", a);
        send_byte(8'h00, 1'b1, "R3", a);
        start_c();
        send_byte(8'hAB, 1'b1, "R3", a);
        exp_q.push_back(ram_m[0]);
        recv_check(1'b0, "R3");
        stop_c();

        hold(20);
        chk(!scl_pull && !sda_pull, "R1", "lines idle at end", {scl_pull, sda_pull}, 0);
        chk(rst_bad == 0, "R1", "pulls seen in reset", rst_bad, 0);
        chk(od_bad == 0, "R11", "SDA changes during SCL high", od_bad, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule